// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two N-bit operands over several clock cycles, retiring two multiplier bits per cycle. Each cycle it looks at an overlapping three-bit window of the multiplier, starting at the least significant end. From that window it picks a signed digit in {-2, -1, 0, +1, +2}. It adds the matching multiple of the multiplicand (0, ±A or ±2A) to a running partial product, then shifts the combined accumulator/multiplier register right by two places. A mode input chosen at launch treats both operands as two's-complement or as unsigned.

A caller waits for `ready`, presents the operands and mode, and pulses `start`. After a fixed number of steps, `done` rises for one cycle. The 2N-bit product then stays on `product` until the next operation completes. `ready` is already high in the cycle where `done` is high, so operations can run back to back.

Top module: `booth_seq_mul`

## Requirements
- R1: During and right after reset, `ready` is 1, `done` is 0 and `product` is 0.
- R2: `start` is accepted only while `ready` is 1. A `start` raised while an operation is running, with any operand values, has no effect on the result returned for the running operation.
- R3: With `is_signed` = 1, `product` equals the 2N-bit two's-complement product of `a_in` and `x_in`, both read as two's-complement, including the case where both operands are -2^(N-1).
- R4: With `is_signed` = 0, `product` equals the 2N-bit unsigned product of `a_in` and `x_in`, including (2^N-1)·(2^N-1).
- R5: The step count S is N/2 for a signed operation with even N. Otherwise S is floor(N/2)+1, because zeros or sign copies are appended above the multiplier to complete the last window. `done` is first seen high after the (S+1)-th rising edge, counting the edge that accepts `start` as the first. For N=8 this gives 5 edges signed and 6 unsigned.
- R6: `done` is high for exactly one cycle per operation.
- R7: `product` changes only in the cycle where `done` rises. Between operations it holds its value while the inputs change.
- R8: `ready` is 0 from the cycle after an accepted `start` until the final step, and is 1 again in the cycle where `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, taken when `ready` is 1 |
| a_in | input | N | Multiplicand |
| x_in | input | N | Multiplier |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| ready | output | 1 | Idle and able to accept `start` |
| done | output | 1 | One-cycle pulse when the product is updated |
| product | output | 2N | Result of the last completed operation |

## Verification
The checker assumes that operands and mode are valid in the cycle where `start` meets `ready`. It latches them only there, so values on `a_in`, `x_in` and `is_signed` at any other time are free. The bench changes inputs only at falling edges. It launches each new operation at the falling edge where `done` is seen, which exercises the back-to-back path. It deliberately pulses `start` with unrelated operands while busy, to show that those values are never latched.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        MAG_ZERO = 2'd0,
        MAG_ONE  = 2'd1,
        MAG_TWO  = 2'd2
    } mag_e;

    typedef struct packed {
        logic neg;
        mag_e mag;
    } digit_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    // window = {x_hi, x_lo, ref}; digit value = x_lo + ref - 2*x_hi
    function automatic digit_t recode(input logic [2:0] window);
        digit_t d;
        d.neg = 1'b0;
        d.mag = MAG_ZERO;
        unique case (window)
            3'b001, 3'b010: d.mag = MAG_ONE;
            3'b011:         d.mag = MAG_TWO;
            3'b100: begin   d.mag = MAG_TWO; d.neg = 1'b1; end
            3'b101, 3'b110: begin d.mag = MAG_ONE; d.neg = 1'b1; end
            default:        d.mag = MAG_ZERO;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
(
    input  logic [2:0] window,
    output digit_t     digit
);
    always_comb digit = recode(window);
endmodule

// File: rtl/booth_multiple.sv
module booth_multiple
    import booth_pkg::*;
#(
    parameter int AW = 9,
    parameter int HW = 11
) (
    input  logic [AW-1:0] a_ext,
    input  digit_t        digit,
    output logic [HW-1:0] operand,
    output logic          carry_in
);
    localparam int EXT = HW - AW;

    logic [HW-1:0] a_wide;
    logic [HW-1:0] mult;

    always_comb begin
        a_wide = {{EXT{a_ext[AW-1]}}, a_ext};
        unique case (digit.mag)
            MAG_ONE: mult = a_wide;
            MAG_TWO: mult = {a_wide[HW-2:0], 1'b0};
            default: mult = '0;
        endcase
        operand  = digit.neg ? ~mult : mult;
        carry_in = digit.neg;
    end
endmodule

// File: rtl/booth_step.sv
module booth_step #(
    parameter int HW = 11,
    parameter int XW = 10
) (
    input  logic [HW-1:0] hi,
    input  logic [XW-1:0] lo,
    input  logic [HW-1:0] operand,
    input  logic          carry_in,
    output logic [HW-1:0] hi_next,
    output logic [XW-1:0] lo_next
);
    localparam int TW = HW + XW;

    logic [HW-1:0] sum;
    logic [TW-1:0] joined;

    always_comb begin
        sum = hi + operand + {{(HW-1){1'b0}}, carry_in};
        joined = {sum, lo};
        {hi_next, lo_next} = {{2{sum[HW-1]}}, joined[TW-1:2]};
    end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] last_idx,
    output logic          ready,
    output logic          load,
    output logic          step,
    output logic          final_step
);
    state_e        state;
    logic [CW-1:0] cnt;

    always_comb begin
        ready      = (state == ST_IDLE);
        load       = ready && start;
        step       = (state == ST_RUN);
        final_step = step && (cnt == last_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (load) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else if (final_step) begin
            state <= ST_IDLE;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N-1:0]   a_in,
    input  logic [N-1:0]   x_in,
    input  logic           is_signed,
    output logic           ready,
    output logic           done,
    output logic [2*N-1:0] product
);
    localparam int  AW       = N + 1;
    localparam int  HW       = N + 3;
    localparam int  XW       = (N % 2 == 0) ? N + 2 : N + 1;
    localparam int  FULL_IDX = XW / 2 - 1;
    localparam int  CW       = $clog2(XW / 2 + 1);
    localparam bit  EVEN_N   = (N % 2 == 0);

    logic [HW-1:0] hi_q, hi_n;
    logic [XW-1:0] lo_q, lo_n;
    logic          ref_q;
    logic [AW-1:0] a_q;
    logic          short_q;
    logic [CW-1:0] last_idx;
    logic          load, step, final_step;
    digit_t        digit;
    logic [HW-1:0] operand;
    logic          carry_in;
    logic [HW+XW-1:0] full_n;

    always_comb begin
        if (short_q) last_idx = CW'(FULL_IDX - 1);
        else         last_idx = CW'(FULL_IDX);
        full_n = {hi_n, lo_n};
    end

    booth_ctrl #(.CW(CW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .last_idx   (last_idx),
        .ready      (ready),
        .load       (load),
        .step       (step),
        .final_step (final_step)
    );

    booth_recoder u_rec (
        .window ({lo_q[1:0], ref_q}),
        .digit  (digit)
    );

    booth_multiple #(.AW(AW), .HW(HW)) u_mult (
        .a_ext    (a_q),
        .digit    (digit),
        .operand  (operand),
        .carry_in (carry_in)
    );

    booth_step #(.HW(HW), .XW(XW)) u_step (
        .hi       (hi_q),
        .lo       (lo_q),
        .operand  (operand),
        .carry_in (carry_in),
        .hi_next  (hi_n),
        .lo_next  (lo_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q    <= '0;
            lo_q    <= '0;
            ref_q   <= 1'b0;
            a_q     <= '0;
            short_q <= 1'b0;
            done    <= 1'b0;
            product <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                hi_q    <= '0;
                lo_q    <= {{(XW-N){is_signed & x_in[N-1]}}, x_in};
                ref_q   <= 1'b0;
                a_q     <= {is_signed & a_in[N-1], a_in};
                short_q <= is_signed && EVEN_N;
            end else if (step) begin
                hi_q  <= hi_n;
                lo_q  <= lo_n;
                ref_q <= lo_q[1];
                if (final_step) begin
                    done <= 1'b1;
                    if (short_q) product <= full_n[2*N+1:2];
                    else         product <= full_n[2*N-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/booth_chk.sv
module booth_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [N-1:0]   a_in,
    input logic [N-1:0]   x_in,
    input logic           is_signed,
    input logic           ready,
    input logic           done,
    input logic [2*N-1:0] product
);
    localparam int SIGNED_STEPS   = (N % 2 == 0) ? N / 2 : N / 2 + 1;
    localparam int UNSIGNED_STEPS = N / 2 + 1;

    logic [2*N-1:0] exp_q;
    logic [7:0]     lat_q;
    logic [7:0]     exp_lat_q;
    logic [2*N-1:0] sa, sx;

    always_comb begin
        sa = is_signed ? {{N{a_in[N-1]}}, a_in} : {{N{1'b0}}, a_in};
        sx = is_signed ? {{N{x_in[N-1]}}, x_in} : {{N{1'b0}}, x_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q     <= '0;
            lat_q     <= '0;
            exp_lat_q <= '0;
        end else if (ready && start) begin
            exp_q     <= sa * sx;
            lat_q     <= 8'd1;
            exp_lat_q <= 8'(is_signed ? SIGNED_STEPS + 1 : UNSIGNED_STEPS + 1);
        end else if (!ready) begin
            lat_q <= lat_q + 8'd1;
        end
    end

    // R3 and R4
    p_product_r3_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> product == exp_q);
    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> lat_q == exp_lat_q);
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(product));
    p_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (ready && start) |=> !ready);
    p_done_ready_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> ready);
    p_ready_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> done);
endmodule

bind booth_seq_mul booth_chk #(.N(N)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .a_in      (a_in),
    .x_in      (x_in),
    .is_signed (is_signed),
    .ready     (ready),
    .done      (done),
    .product   (product)
);

// File: tb/test_booth_seq_mul.sv
module test_booth_seq_mul;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [N-1:0]   a_in = '0;
    logic [N-1:0]   x_in = '0;
    logic           is_signed = 1'b0;
    logic           ready, done;
    logic [2*N-1:0] product;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cycles++;

    booth_seq_mul #(.N(N)) i_booth_seq_mul (
        .clk(clk), .rst(rst), .start(start), .a_in(a_in), .x_in(x_in),
        .is_signed(is_signed), .ready(ready), .done(done), .product(product)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint expect_prod(input logic [N-1:0] a, input logic [N-1:0] x, input logic sg);
        longint va, vx;
        va = sg ? longint'($signed(a)) : longint'(a);
        vx = sg ? longint'($signed(x)) : longint'(x);
        return (va * vx) & ((64'd1 << (2*N)) - 1);
    endfunction

    // call at a falling edge where ready is high; returns at the falling edge where done is seen
    task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] x, input logic sg, input bit chk_lat);
        int n;
        int s;
        a_in = a; x_in = x; is_signed = sg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        if (sg) check(longint'(product) == expect_prod(a, x, sg), "R3", product, expect_prod(a, x, sg));
        else    check(longint'(product) == expect_prod(a, x, sg), "R4", product, expect_prod(a, x, sg));
        if (chk_lat) begin
            s = sg ? ((N % 2 == 0) ? N/2 : N/2 + 1) : N/2 + 1;
            check(n == s + 1, "R5", n, s + 1);
        end
    endtask

    initial begin
        wait (cycles >= 195000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 195000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check(ready == 1'b1, "R1", ready, 1);
        check(done == 1'b0, "R1", done, 0);
        check(product == '0, "R1", product, 0);
        rst = 1'b0;
        @(negedge clk);
        check(ready == 1'b1 && done == 1'b0 && product == '0, "R1", product, 0);

        // R8: busy after accept, ready with done
        a_in = 8'd3; x_in = 8'd5; is_signed = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(ready == 1'b0, "R8", ready, 0);
        while (!done) @(negedge clk);
        check(ready == 1'b1, "R8", ready, 1);
        check(product == 16'd15, "R3", product, 15);
        // R6: done single cycle
        @(negedge clk);
        check(done == 1'b0, "R6", done, 0);

        // R2: start with other operands while busy is ignored
        a_in = 8'd7; x_in = 8'd9; is_signed = 1'b1; start = 1'b1;
        @(negedge clk);
        a_in = 8'd100; x_in = 8'd100; is_signed = 1'b0;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check(product == 16'd63, "R2", product, 63);
        // R7: product held while inputs change and start stays low
        a_in = 8'hAA; x_in = 8'h55; is_signed = 1'b0;
        repeat (4) @(negedge clk);
        check(product == 16'd63, "R7", product, 63);
        check(done == 1'b0, "R6", done, 0);

        // boundary operands
        run_op(8'h80, 8'h80, 1'b1, 1'b1);
        check(product == 16'h4000, "R3", product, 16'h4000);
        run_op(8'hFF, 8'hFF, 1'b0, 1'b1);
        check(product == 16'hFE01, "R4", product, 16'hFE01);
        run_op(8'h7F, 8'h80, 1'b1, 1'b1);
        run_op(8'hFF, 8'h01, 1'b1, 1'b1);
        run_op(8'h00, 8'hFF, 1'b0, 1'b1);
        run_op(8'hAA, 8'h55, 1'b1, 1'b1);

        // near-exhaustive sweep, back to back, both modes
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 256; a++) begin
                for (int j = 0; j < 32; j++) begin
                    run_op(N'(a), N'((j * 8 + a) & 255), m[0], (j == 0));
                end
            end
        end

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule